// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a software-supervised watchdog. A prescaler turns the core clock into a slow tick, and a 10-bit counter steps down once per tick from a programmable start value. When the counter has reached zero and one more tick arrives, the counter expires. On expiry it reloads the start value and keeps counting.

Expiry works in two stages. The first expiry only raises a first-stage flag. If the counter expires again while that flag is still set, a second-stage flag is raised and a one-cycle reset request is sent to the system reset logic. A no-reboot control bit can suppress that request. Software keeps the system alive in one of two ways: it kicks the counter back to its start value, or it clears the first-stage flag so that two expiries are needed again.

Software reaches the block through a flat 16-bit register port with byte addresses. Writes are single-cycle strobes and reads are combinational. The port gives access to the kick and count readback, two status registers with write-one-to-clear bits, a control register holding the halt and no-reboot bits, and the start-value register.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the registers read as follows: halt=1 and no-reboot=1 (control at 0x08 reads 0x0801), all status flags are 0, the start value equals the INIT_DEFAULT parameter (at least 4), the count equals the start value, and rst_req is 0.
- R2: While the counter is not halted, one tick occurs every PRESCALE clock cycles and each tick lowers the count by one. A read of 0x00 returns the count in bits [9:0] with zeros above.
- R3: Any write to 0x00, whatever the data, loads the count with the start value and restarts the prescaler phase. The next tick therefore arrives PRESCALE cycles after the write.
- R4: A write to 0x12 always stores data bits [15:10]. It stores data bits [9:0] as the new start value only when that value is 4 or more; values 0 to 3 leave the stored start value unchanged.
- R5: When control bit 11 (halt) is 1, the count and the prescaler are frozen. When it is 0, the counter runs.
- R6: A tick that arrives while the count is 0 is an expiry. An expiry reloads the start value, and the counter keeps running. If the first-stage flag (0x04 bit 3) is clear, the expiry sets it.
- R7: An expiry that happens while the first-stage flag is set raises the second-stage flag (0x06 bit 1), which stays set until it is cleared. If no-reboot is 0, the same expiry also raises rst_req for exactly one cycle, in the cycle after the expiring tick.
- R8: While control bit 0 (no-reboot) is 1, rst_req stays low, including on a second-stage expiry.
- R9: Status bits are cleared by writing 1 to them, and writing 0 has no effect. Clearing the first-stage flag between expiries means two further expiries are needed before a reset request.
- R10: The boot flag (0x06 bit 2) is set by an expiry that finds both the first-stage and the second-stage flags set, and it is cleared by writing 1 to it.
- R11: Reads of unmapped offsets return 0, and the control bits other than 11 and 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with PRESCALE=3 and INIT_DEFAULT=5. With these values a full expiry period is only 3×(start+1) cycles, so the bench can check every tick of the count against arithmetic on the cycle number. It also steps through many first-stage, second-stage and boot-flag sequences in a few hundred cycles. The short period lets the bench write all 1024 possible start values and check the acceptance rule for each one. It also runs tick-exact countdowns for start values 4 through 8, checking that the reset request comes only on a second consecutive expiry and is gated by the no-reboot bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFS_KICK   = 8'h00;
  localparam logic [7:0] OFS_STAT1  = 8'h04;
  localparam logic [7:0] OFS_STAT2  = 8'h06;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_START  = 8'h12;

  localparam int BIT_FIRST   = 3;   // status1
  localparam int BIT_SECOND  = 1;   // status2
  localparam int BIT_BOOT    = 2;   // status2
  localparam int BIT_HALT    = 11;  // control
  localparam int BIT_NOBOOT  = 0;   // control

  localparam int START_MIN   = 4;

  typedef struct packed {
    logic first;
    logic second;
    logic boot;
  } wdog_flags_t;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int PRESCALE = 60_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = run && !restart;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] phase_q, phase_d;
      logic          wrap;

      assign wrap = (phase_q == LAST);
      assign tick = run && !restart && wrap;

      always_comb begin
        phase_d = phase_q;
        if (restart || !run)  phase_d = '0;
        else if (wrap)        phase_d = '0;
        else                  phase_d = phase_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int CNT_W = 10,
  parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(4)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = tick && at_zero && !reload;
  assign count   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (reload)       cnt_d = load_val;
    else if (tick) begin
      if (at_zero)    cnt_d = load_val;
      else            cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wdog_stage_ctl.sv
module wdog_stage_ctl
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        expire,
  input  logic        no_reboot,
  input  logic        clr_first,
  input  logic        clr_second,
  input  logic        clr_boot,
  output wdog_flags_t flags,
  output logic        rst_req
);
  wdog_flags_t fl_q, fl_d;
  logic        req_q, req_d;

  always_comb begin
    fl_d  = fl_q;
    req_d = 1'b0;
    if (clr_first)  fl_d.first  = 1'b0;
    if (clr_second) fl_d.second = 1'b0;
    if (clr_boot)   fl_d.boot   = 1'b0;
    if (expire) begin
      if (fl_q.first) begin
        fl_d.second = 1'b1;
        if (fl_q.second) fl_d.boot = 1'b1;
        req_d = !no_reboot;
      end else begin
        fl_d.first = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= '0;
      req_q <= 1'b0;
    end else begin
      fl_q  <= fl_d;
      req_q <= req_d;
    end
  end

  assign flags   = fl_q;
  assign rst_req = req_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int PRESCALE     = 60_000_000,
  parameter int CNT_W        = 10,
  parameter int DATA_W       = 16,
  parameter int ADDR_W       = 8,
  parameter int INIT_DEFAULT = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int HI_W = DATA_W - CNT_W;
  localparam logic [CNT_W-1:0] START_RST = CNT_W'(INIT_DEFAULT);

  // reset synchronizer: async assert, sync release
  logic [1:0] rsync_q;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  // write decode
  logic wr_kick, wr_stat1, wr_stat2, wr_ctrl, wr_start;
  assign wr_kick  = bus_wr && (bus_addr == ADDR_W'(OFS_KICK));
  assign wr_stat1 = bus_wr && (bus_addr == ADDR_W'(OFS_STAT1));
  assign wr_stat2 = bus_wr && (bus_addr == ADDR_W'(OFS_STAT2));
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_start = bus_wr && (bus_addr == ADDR_W'(OFS_START));

  // control and start-value storage
  logic             ctrl_halt_q, ctrl_halt_d;
  logic             ctrl_noboot_q, ctrl_noboot_d;
  logic [CNT_W-1:0] start_q, start_d;
  logic [HI_W-1:0]  start_hi_q, start_hi_d;
  logic             start_ok;

  assign start_ok = (bus_wdata[CNT_W-1:0] >= CNT_W'(START_MIN));

  always_comb begin
    ctrl_halt_d   = ctrl_halt_q;
    ctrl_noboot_d = ctrl_noboot_q;
    start_d       = start_q;
    start_hi_d    = start_hi_q;
    if (wr_ctrl) begin
      ctrl_halt_d   = bus_wdata[BIT_HALT];
      ctrl_noboot_d = bus_wdata[BIT_NOBOOT];
    end
    if (wr_start) begin
      start_hi_d = bus_wdata[DATA_W-1:CNT_W];
      if (start_ok) start_d = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      ctrl_halt_q   <= 1'b1;
      ctrl_noboot_q <= 1'b1;
      start_q       <= START_RST;
      start_hi_q    <= '0;
    end else begin
      ctrl_halt_q   <= ctrl_halt_d;
      ctrl_noboot_q <= ctrl_noboot_d;
      start_q       <= start_d;
      start_hi_q    <= start_hi_d;
    end
  end

  // datapath
  logic             tick;
  logic             expire;
  logic [CNT_W-1:0] count_val;
  wdog_flags_t      flags;

  wdog_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .run     (!ctrl_halt_q),
    .restart (wr_kick),
    .tick    (tick)
  );

  wdog_down_counter #(.CNT_W(CNT_W), .RST_VAL(START_RST)) u_cnt (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .tick     (tick),
    .reload   (wr_kick),
    .load_val (start_q),
    .count    (count_val),
    .expire   (expire)
  );

  wdog_stage_ctl u_stage (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .expire     (expire),
    .no_reboot  (ctrl_noboot_q),
    .clr_first  (wr_stat1 && bus_wdata[BIT_FIRST]),
    .clr_second (wr_stat2 && bus_wdata[BIT_SECOND]),
    .clr_boot   (wr_stat2 && bus_wdata[BIT_BOOT]),
    .flags      (flags),
    .rst_req    (rst_req)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_W'(OFS_KICK):  bus_rdata[CNT_W-1:0] = count_val;
      ADDR_W'(OFS_STAT1): bus_rdata[BIT_FIRST] = flags.first;
      ADDR_W'(OFS_STAT2): begin
        bus_rdata[BIT_SECOND] = flags.second;
        bus_rdata[BIT_BOOT]   = flags.boot;
      end
      ADDR_W'(OFS_CTRL): begin
        bus_rdata[BIT_HALT]   = ctrl_halt_q;
        bus_rdata[BIT_NOBOOT] = ctrl_noboot_q;
      end
      ADDR_W'(OFS_START): bus_rdata = {start_hi_q, start_q};
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             halt,
  input logic             noboot,
  input logic             kick,
  input logic             expire,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] start,
  input logic             first,
  input logic             second,
  input logic             rst_req
);
  // R7
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8
  noboot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(noboot));

  // R7
  rst_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> second);

  // R5
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(kick)) |-> $stable(count));

  // R4
  start_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start >= CNT_W'(4));

  // R6
  first_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(first) |-> $past(expire));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(kick) && !$past(expire) && (count != $past(count)))
      |-> (count == CNT_W'($past(count) - 1'b1)));
endmodule

bind wdog_two_stage wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (core_rst_n),
  .halt    (ctrl_halt_q),
  .noboot  (ctrl_noboot_q),
  .kick    (wr_kick),
  .expire  (expire),
  .count   (count_val),
  .start   (start_q),
  .first   (flags.first),
  .second  (flags.second),
  .rst_req (rst_req)
);

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam int P  = 3;
  localparam int ID = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        rst_req;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  int rst_cnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (rst_req === 1'b1) rst_cnt <= rst_cnt + 1;

  wdog_two_stage #(.PRESCALE(P), .INIT_DEFAULT(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int e0;
    int prev;
    int held;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 8'h00; bus_wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h08, d); check("R1 ctrl", d, 16'h0801);
    rd(8'h04, d); check("R1 stat1", d, 16'h0000);
    rd(8'h06, d); check("R1 stat2", d, 16'h0000);
    rd(8'h12, d); check("R1 start", d, 16'(ID));
    rd(8'h00, d); check("R1 count", d, 16'(ID));
    check("R1 rst_req", {15'b0, rst_req}, 16'h0);

    // R4 sweep of all start values
    prev = ID;
    for (int v = 0; v < 1024; v++) begin
      wr(8'h12, {6'(v), 10'(v)});
      if (v >= 4) prev = v;
      rd(8'h12, d);
      check("R4 start write", d, {6'(v), 10'(prev)});
    end

    // R5 halted counter stays frozen
    wr(8'h00, 16'h0001); e0 = cyc;
    wait_to(e0 + 5 * P);
    rd(8'h00, d); check("R5 halted count", d, 16'd1023);

    // R2 R3 R6 tick-exact countdowns, no-reboot set
    wr(8'h08, 16'h0001);
    for (int iv = 4; iv <= 8; iv++) begin
      wr(8'h12, 16'(iv));
      wr(8'h04, 16'h0008);
      wr(8'h06, 16'h0006);
      wr(8'h00, 16'h1234); e0 = cyc;
      for (int n = 0; n <= iv; n++) begin
        wait_to(e0 + n * P);
        rd(8'h00, d); check(n == 0 ? "R3 kick load" : "R2 countdown", d, 16'(iv - n));
      end
      wait_to(e0 + (iv + 1) * P);
      rd(8'h00, d); check("R6 reload on expiry", d, 16'(iv));
      rd(8'h04, d); check("R6 first flag", d, 16'h0008);
      rd(8'h06, d); check("R6 no second yet", d, 16'h0000);
    end
    // second expiry of the last run with no-reboot set
    wait_to(e0 + 18 * P);
    rd(8'h06, d); check("R7 second flag", d, 16'h0002);
    check("R8 no reset pulse", 16'(rst_cnt), 16'd0);

    // R9 write-one-to-clear
    wr(8'h04, 16'h0000); rd(8'h04, d); check("R9 w0 stat1", d, 16'h0008);
    wr(8'h04, 16'h0008); rd(8'h04, d); check("R9 w1 stat1", d, 16'h0000);
    wr(8'h06, 16'h0000); rd(8'h06, d); check("R9 w0 stat2", d, 16'h0002);
    wr(8'h06, 16'h0002); rd(8'h06, d); check("R9 w1 stat2", d, 16'h0000);

    // R11 unused control bits and unmapped offsets
    wr(8'h08, 16'hFFFF); rd(8'h08, d); check("R11 ctrl bits", d, 16'h0801);
    rd(8'h02, d); check("R11 unmapped 02", d, 16'h0000);
    rd(8'h0A, d); check("R11 unmapped 0A", d, 16'h0000);
    rd(8'h10, d); check("R11 unmapped 10", d, 16'h0000);

    // R7 reset pulse on second consecutive expiry
    wr(8'h08, 16'h0000);
    wr(8'h12, 16'd6);
    wr(8'h00, 16'h0000); e0 = cyc;
    wait_to(e0 + 7 * P);
    rd(8'h04, d); check("R6 first flag run2", d, 16'h0008);
    check("R7 no pulse on first", {15'b0, rst_req}, 16'h0);
    wait_to(e0 + 14 * P);
    check("R7 pulse high", {15'b0, rst_req}, 16'h1);
    rd(8'h06, d); check("R7 second set", d, 16'h0002);
    @(negedge clk);
    check("R7 pulse one cycle", {15'b0, rst_req}, 16'h0);
    check("R7 pulse count", 16'(rst_cnt), 16'd1);

    // R10 boot flag on third expiry, no-reboot set
    wr(8'h08, 16'h0001);
    wr(8'h00, 16'h0000); e0 = cyc;
    wait_to(e0 + 7 * P);
    rd(8'h06, d); check("R10 boot set", d, 16'h0006);
    check("R8 suppressed", 16'(rst_cnt), 16'd1);
    wr(8'h06, 16'h0004); rd(8'h06, d); check("R10 boot clear", d, 16'h0002);
    wr(8'h06, 16'h0002);
    wr(8'h04, 16'h0008);

    // R9 clearing first flag restarts the two-expiry count
    wr(8'h08, 16'h0000);
    wr(8'h00, 16'h0000); e0 = cyc;
    wait_to(e0 + 7 * P);
    rd(8'h04, d); check("R9 first again", d, 16'h0008);
    wr(8'h04, 16'h0008);
    rd(8'h04, d); check("R9 cleared", d, 16'h0000);
    wait_to(e0 + 14 * P);
    rd(8'h04, d); check("R9 re-armed", d, 16'h0008);
    rd(8'h06, d); check("R9 no second", d, 16'h0000);
    @(negedge clk);
    check("R9 no reset", 16'(rst_cnt), 16'd1);

    // R5 halt in mid-run
    wr(8'h00, 16'h0000); e0 = cyc;
    wait_to(e0 + 2 * P);
    wr(8'h08, 16'h0800);
    rd(8'h00, d); held = d; check("R5 count at halt", d, 16'd4);
    repeat (5 * P) @(negedge clk);
    rd(8'h00, d); check("R5 frozen", d, 16'(held));
    rd(8'h04, d); check("R5 no expiry", d, 16'h0008);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule